// File: doc/BRIEF.md
# Token-Ordered Transmit Queue Sequencer

This block orders outgoing frames held in a small bank of message slots (16 by default). Software marks one slot as a queue head and a contiguous run of other slots as its members. Each slot carries a single transmit-permit bit. Within a queue only one member holds the permit at a time, so the permit acts as a token. The head slot keeps a pointer to the member that holds the token. It also keeps the low and high bounds of its member run and an alarm index.

Software loads every slot field through a one-field-per-cycle write port. Each cycle the block registers which slot may be sent next: the lowest-numbered slot that is valid, requested and permitted. A completion pulse arrives from the bus side with a slot number. The block then clears that slot's request and pulses a transmit interrupt. If the slot is the head's current member, the block also passes the token to the next member, wrapping from the high bound to the low bound. It moves the head pointer with the token, and it can raise an alarm pulse when the pointer lands on the alarm index.

Top module: `txq_token_seq`

## Requirements
- R1: After reset, win_valid, tx_irq and ovf_irq are all 0, and every slot field is 0.
- R2: A slot can be selected only when its valid, request and permit bits are all 1. With no such slot, win_valid is 0.
- R3: Among eligible slots the lowest index wins. win_valid/win_slot reflect the slot state one clock after that state is registered.
- R4: A tx_done pulse for slot s clears the request of s. In the following cycle it gives tx_irq=1 for exactly one cycle, with tx_irq_slot=s.
- R5: If slot s has mode 4'b0011, its pointer names a slot b of mode 4'b0010, and b's pointer equals s, then tx_done for s does three things. It clears the permit of s, sets the permit of the next member n, and loads b's pointer with n.
- R6: The next member n is s+1 (modulo the slot count), except when s equals b's high bound, where n is b's low bound.
- R7: When such an advance occurs, b's overflow enable is 1 and n equals b's alarm index, ovf_irq is 1 for one cycle with ovf_base=b. This happens in the cycle after tx_done, on the same edge that loads the pointer.
- R8: With b's overflow enable at 0, or n different from the alarm index, an advance raises no ovf_irq.
- R9: tx_done for a slot that is not the current member of a valid head leaves every permit and pointer unchanged. Only its request is cleared.
- R10: A cfg_we write updates one field of slot cfg_slot at the clock edge, using the low bits of cfg_data. The field codes are: 0 mode (4 bits), 1 valid, 2 request, 3 permit, 4 pointer, 5 low bound, 6 high bound, 7 alarm index, 8 overflow enable. Single-bit fields use bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Field write strobe |
| cfg_slot | input | IDX_W | Slot written |
| cfg_field | input | 4 | Field code (see R10) |
| cfg_data | input | DATA_W | Write data, low bits used |
| tx_done | input | 1 | Transmission completed pulse |
| tx_done_slot | input | IDX_W | Slot that completed |
| win_valid | output | 1 | A slot is selected |
| win_slot | output | IDX_W | Selected slot index |
| tx_irq | output | 1 | Transmit interrupt pulse |
| tx_irq_slot | output | IDX_W | Slot of the transmit interrupt |
| ovf_irq | output | 1 | Queue alarm pulse |
| ovf_base | output | IDX_W | Head slot raising the alarm |

## Verification
The assertions assume that software never writes a slot's permit or pointer on the same edge at which a completion moves that token. They also assume the member runs are well formed: each member lies between its head's bounds, and the low bound is not above the high bound. The bench keeps within this in two ways. It issues configuration writes and completion pulses in separate cycles, and it builds one head with members 4 to 7 whose pointers all name that head. Completions for non-current members and for ordinary slots are still issued, because those are defined cases.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [3:0] {
    FLD_MODE  = 4'd0,
    FLD_VALID = 4'd1,
    FLD_TXREQ = 4'd2,
    FLD_TOKEN = 4'd3,
    FLD_CUR   = 4'd4,
    FLD_LOW   = 4'd5,
    FLD_HIGH  = 4'd6,
    FLD_SEL   = 4'd7,
    FLD_OVIE  = 4'd8
  } fld_e;

  localparam logic [3:0] MODE_HEAD   = 4'b0010;
  localparam logic [3:0] MODE_MEMBER = 4'b0011;
endpackage

// File: rtl/txq_slot_bank.sv
module txq_slot_bank
  import txq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = 4,
  parameter int DATA_W    = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [IDX_W-1:0]                cfg_slot,
  input  logic [3:0]                      cfg_field,
  input  logic [DATA_W-1:0]               cfg_data,
  input  logic                            tx_done,
  input  logic [IDX_W-1:0]                tx_done_slot,
  input  logic                            adv_fire,
  input  logic [IDX_W-1:0]                adv_base,
  input  logic [IDX_W-1:0]                adv_member,
  input  logic [IDX_W-1:0]                adv_next,
  output logic [NUM_SLOTS-1:0][3:0]       mode_q,
  output logic [NUM_SLOTS-1:0]            valid_q,
  output logic [NUM_SLOTS-1:0]            txreq_q,
  output logic [NUM_SLOTS-1:0]            token_q,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0] cur_q,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0] low_q,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0] high_q,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0] sel_q,
  output logic [NUM_SLOTS-1:0]            ovie_q
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic             wr_hit, done_hit, tok_drop, tok_take, ptr_load;
    logic [3:0]       mode_r;
    logic             valid_r, txreq_r, token_r, ovie_r;
    logic [IDX_W-1:0] cur_r, low_r, high_r, sel_r;

    assign wr_hit   = cfg_we && (cfg_slot == IDX_W'(i));
    assign done_hit = tx_done && (tx_done_slot == IDX_W'(i));
    assign tok_drop = adv_fire && (adv_member == IDX_W'(i));
    assign tok_take = adv_fire && (adv_next == IDX_W'(i));
    assign ptr_load = adv_fire && (adv_base == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_r  <= '0;
        valid_r <= 1'b0;
        txreq_r <= 1'b0;
        token_r <= 1'b0;
        ovie_r  <= 1'b0;
        cur_r   <= '0;
        low_r   <= '0;
        high_r  <= '0;
        sel_r   <= '0;
      end else begin
        if (wr_hit) begin
          case (fld_e'(cfg_field))
            FLD_MODE:  mode_r  <= cfg_data[3:0];
            FLD_VALID: valid_r <= cfg_data[0];
            FLD_TXREQ: txreq_r <= cfg_data[0];
            FLD_TOKEN: token_r <= cfg_data[0];
            FLD_CUR:   cur_r   <= cfg_data[IDX_W-1:0];
            FLD_LOW:   low_r   <= cfg_data[IDX_W-1:0];
            FLD_HIGH:  high_r  <= cfg_data[IDX_W-1:0];
            FLD_SEL:   sel_r   <= cfg_data[IDX_W-1:0];
            FLD_OVIE:  ovie_r  <= cfg_data[0];
            default:   ;
          endcase
        end
        // hardware events override a same-cycle write of the same field
        if (done_hit) txreq_r <= 1'b0;
        if (tok_drop) token_r <= 1'b0;
        if (tok_take) token_r <= 1'b1;
        if (ptr_load) cur_r   <= adv_next;
      end
    end

    assign mode_q[i]  = mode_r;
    assign valid_q[i] = valid_r;
    assign txreq_q[i] = txreq_r;
    assign token_q[i] = token_r;
    assign ovie_q[i]  = ovie_r;
    assign cur_q[i]   = cur_r;
    assign low_q[i]   = low_r;
    assign high_q[i]  = high_r;
    assign sel_q[i]   = sel_r;
  end
endmodule

// File: rtl/txq_advance.sv
module txq_advance
  import txq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = 4
) (
  input  logic                            tx_done,
  input  logic [IDX_W-1:0]                tx_done_slot,
  input  logic [NUM_SLOTS-1:0][3:0]       mode_q,
  input  logic [NUM_SLOTS-1:0][IDX_W-1:0] cur_q,
  input  logic [NUM_SLOTS-1:0][IDX_W-1:0] low_q,
  input  logic [NUM_SLOTS-1:0][IDX_W-1:0] high_q,
  input  logic [NUM_SLOTS-1:0][IDX_W-1:0] sel_q,
  input  logic [NUM_SLOTS-1:0]            ovie_q,
  output logic                            adv_fire,
  output logic [IDX_W-1:0]                adv_base,
  output logic [IDX_W-1:0]                adv_member,
  output logic [IDX_W-1:0]                adv_next,
  output logic                            adv_ovf
);
  // successor inside the member run, wrapping at the high bound
  function automatic logic [IDX_W-1:0] step_member(
    input logic [IDX_W-1:0] idx,
    input logic [IDX_W-1:0] lo,
    input logic [IDX_W-1:0] hi
  );
    if (idx == hi) return lo;
    return idx + IDX_W'(1);
  endfunction

  logic is_member, head_ok, is_current;

  always_comb begin
    adv_member = tx_done_slot;
    adv_base   = cur_q[tx_done_slot];
    is_member  = (mode_q[tx_done_slot] == MODE_MEMBER);
    head_ok    = (mode_q[adv_base] == MODE_HEAD);
    is_current = (cur_q[adv_base] == tx_done_slot);
    adv_fire   = tx_done && is_member && head_ok && is_current;
    adv_next   = step_member(tx_done_slot, low_q[adv_base], high_q[adv_base]);
    adv_ovf    = ovie_q[adv_base] && (adv_next == sel_q[adv_base]);
  end
endmodule

// File: rtl/txq_pick.sv
module txq_pick #(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] valid_q,
  input  logic [NUM_SLOTS-1:0] txreq_q,
  input  logic [NUM_SLOTS-1:0] token_q,
  output logic                 win_valid,
  output logic [IDX_W-1:0]     win_slot
);
  // {found, index} of the lowest set bit
  function automatic logic [IDX_W:0] first_set(input logic [NUM_SLOTS-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (v[k]) r = {1'b1, IDX_W'(k)};
    end
    return r;
  endfunction

  logic [NUM_SLOTS-1:0] eligible;
  logic [IDX_W:0]       pick;

  assign eligible = valid_q & txreq_q & token_q;
  assign pick     = first_set(eligible);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_slot  <= '0;
    end else begin
      win_valid <= pick[IDX_W];
      win_slot  <= pick[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/txq_token_seq.sv
module txq_token_seq #(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  parameter int DATA_W    = (IDX_W > 4) ? IDX_W : 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_slot,
  input  logic [3:0]        cfg_field,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              tx_done,
  input  logic [IDX_W-1:0]  tx_done_slot,
  output logic              win_valid,
  output logic [IDX_W-1:0]  win_slot,
  output logic              tx_irq,
  output logic [IDX_W-1:0]  tx_irq_slot,
  output logic              ovf_irq,
  output logic [IDX_W-1:0]  ovf_base
);
  logic [NUM_SLOTS-1:0][3:0]       mode_q;
  logic [NUM_SLOTS-1:0]            valid_q, txreq_q, token_q, ovie_q;
  logic [NUM_SLOTS-1:0][IDX_W-1:0] cur_q, low_q, high_q, sel_q;

  // named internal events
  logic             adv_fire, adv_ovf;
  logic [IDX_W-1:0] adv_base, adv_member, adv_next;

  txq_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .tx_done(tx_done), .tx_done_slot(tx_done_slot),
    .adv_fire(adv_fire), .adv_base(adv_base), .adv_member(adv_member), .adv_next(adv_next),
    .mode_q(mode_q), .valid_q(valid_q), .txreq_q(txreq_q), .token_q(token_q),
    .cur_q(cur_q), .low_q(low_q), .high_q(high_q), .sel_q(sel_q), .ovie_q(ovie_q)
  );

  txq_advance #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_adv (
    .tx_done(tx_done), .tx_done_slot(tx_done_slot),
    .mode_q(mode_q), .cur_q(cur_q), .low_q(low_q), .high_q(high_q),
    .sel_q(sel_q), .ovie_q(ovie_q),
    .adv_fire(adv_fire), .adv_base(adv_base), .adv_member(adv_member),
    .adv_next(adv_next), .adv_ovf(adv_ovf)
  );

  txq_pick #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .valid_q(valid_q), .txreq_q(txreq_q), .token_q(token_q),
    .win_valid(win_valid), .win_slot(win_slot)
  );

  // interrupt pulses, registered on the same edge as the pointer update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_irq      <= 1'b0;
      tx_irq_slot <= '0;
      ovf_irq     <= 1'b0;
      ovf_base    <= '0;
    end else begin
      tx_irq      <= tx_done;
      tx_irq_slot <= tx_done_slot;
      ovf_irq     <= adv_fire && adv_ovf;
      ovf_base    <= adv_base;
    end
  end
endmodule

// File: rtl/txq_token_seq_chk.sv
module txq_token_seq_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int IDX_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tx_done,
  input logic [IDX_W-1:0]     tx_done_slot,
  input logic                 tx_irq,
  input logic [IDX_W-1:0]     tx_irq_slot,
  input logic                 ovf_irq,
  input logic [IDX_W-1:0]     ovf_base,
  input logic                 win_valid,
  input logic [IDX_W-1:0]     win_slot,
  input logic                 adv_fire,
  input logic                 adv_ovf,
  input logic [IDX_W-1:0]     adv_base,
  input logic [IDX_W-1:0]     adv_next,
  input logic [NUM_SLOTS-1:0] token_q,
  input logic [NUM_SLOTS-1:0] valid_q,
  input logic [NUM_SLOTS-1:0] txreq_q
);
  // R4: completion gives one interrupt for the same slot next cycle
  p_irq_follows_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (tx_irq && tx_irq_slot == $past(tx_done_slot)));

  // R4: no interrupt without a completion
  p_irq_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_done |=> !tx_irq);

  // R7: an alarming advance shows up as a pulse for its head
  p_ovf_on_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && adv_ovf) |=> (ovf_irq && ovf_base == $past(adv_base)));

  // R7: an alarm only accompanies a transmit interrupt
  p_ovf_with_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> tx_irq);

  // R5: the token lands on the next member
  p_token_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_fire |=> token_q[$past(adv_next)]);

  // R2: a registered winner was eligible in the state it was chosen from
  p_win_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> ((($past(valid_q & txreq_q & token_q)) >> win_slot) & NUM_SLOTS'(1)) != '0);
endmodule

bind txq_token_seq txq_token_seq_chk #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/txq_token_seq_bench.sv
`timescale 1ns/1ps
module txq_token_seq_bench;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_slot = '0;
  logic [3:0]    cfg_field = '0;
  logic [DW-1:0] cfg_data = '0;
  logic          tx_done = 1'b0;
  logic [IW-1:0] tx_done_slot = '0;
  logic          win_valid, tx_irq, ovf_irq;
  logic [IW-1:0] win_slot, tx_irq_slot, ovf_base;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  txq_token_seq #(.NUM_SLOTS(N)) u_txq_token_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_field(cfg_field), .cfg_data(cfg_data), .tx_done(tx_done),
    .tx_done_slot(tx_done_slot), .win_valid(win_valid), .win_slot(win_slot),
    .tx_irq(tx_irq), .tx_irq_slot(tx_irq_slot), .ovf_irq(ovf_irq), .ovf_base(ovf_base)
  );

  // behavioural reference state
  int m_mode[N], m_valid[N], m_req[N], m_tok[N], m_cur[N];
  int m_lo[N], m_hi[N], m_sel[N], m_oe[N];
  int e_wv = 0, e_ws = 0, e_irq = 0, e_irqs = 0, e_ovf = 0, e_ovfb = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin : model
    int w, s, b, nx;
    cycles++;
    if (!rst_n) begin
      foreach (m_mode[i]) begin
        m_mode[i] = 0; m_valid[i] = 0; m_req[i] = 0; m_tok[i] = 0; m_cur[i] = 0;
        m_lo[i] = 0; m_hi[i] = 0; m_sel[i] = 0; m_oe[i] = 0;
      end
      e_wv = 0; e_ws = 0; e_irq = 0; e_ovf = 0;
    end else begin
      w = -1;
      for (int i = N - 1; i >= 0; i--)
        if (m_valid[i] != 0 && m_req[i] != 0 && m_tok[i] != 0) w = i;
      e_wv = (w >= 0) ? 1 : 0;
      e_ws = (w >= 0) ? w : 0;
      e_irq = tx_done;
      e_irqs = int'(tx_done_slot);
      e_ovf = 0;
      if (cfg_we) begin
        s = int'(cfg_slot);
        case (int'(cfg_field))
          0: m_mode[s]  = int'(cfg_data);
          1: m_valid[s] = int'(cfg_data) % 2;
          2: m_req[s]   = int'(cfg_data) % 2;
          3: m_tok[s]   = int'(cfg_data) % 2;
          4: m_cur[s]   = int'(cfg_data);
          5: m_lo[s]    = int'(cfg_data);
          6: m_hi[s]    = int'(cfg_data);
          7: m_sel[s]   = int'(cfg_data);
          8: m_oe[s]    = int'(cfg_data) % 2;
          default: ;
        endcase
      end
      if (tx_done) begin
        s = int'(tx_done_slot);
        m_req[s] = 0;
        b = m_cur[s];
        if (m_mode[s] == 3 && m_mode[b] == 2 && m_cur[b] == s) begin
          nx = (s == m_hi[b]) ? m_lo[b] : (s + 1) % N;
          m_tok[s] = 0;
          m_tok[nx] = 1;
          m_cur[b] = nx;
          if (m_oe[b] != 0 && nx == m_sel[b]) begin
            e_ovf = 1;
            e_ovfb = b;
          end
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(int'(win_valid) == e_wv, "R3 win_valid", int'(win_valid), e_wv);
      if (e_wv != 0) check(int'(win_slot) == e_ws, "R3 win_slot", int'(win_slot), e_ws);
      check(int'(tx_irq) == e_irq, "R4 tx_irq", int'(tx_irq), e_irq);
      if (e_irq != 0) check(int'(tx_irq_slot) == e_irqs, "R4 tx_irq_slot", int'(tx_irq_slot), e_irqs);
      check(int'(ovf_irq) == e_ovf, "R7 ovf_irq", int'(ovf_irq), e_ovf);
      if (e_ovf != 0) check(int'(ovf_base) == e_ovfb, "R7 ovf_base", int'(ovf_base), e_ovfb);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int s, input int f, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_slot = IW'(s); cfg_field = 4'(f); cfg_data = DW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic done(input int s);
    @(negedge clk);
    tx_done = 1'b1; tx_done_slot = IW'(s);
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic expect_win(input int v, input int s, input string req);
    check(int'(win_valid) == v, req, int'(win_valid), v);
    if (v != 0) check(int'(win_slot) == s, req, int'(win_slot), s);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    tick(4);
    check(win_valid == 1'b0, "R1 win_valid after reset", int'(win_valid), 0);
    check(tx_irq == 1'b0, "R1 tx_irq after reset", int'(tx_irq), 0);
    check(ovf_irq == 1'b0, "R1 ovf_irq after reset", int'(ovf_irq), 0);
    rst_n = 1'b1;
    tick(2);
    check(win_valid == 1'b0, "R1 idle after release", int'(win_valid), 0);

    // R10: head at slot 2, members 4..7, alarm index 6, token on 5
    wr(2, 0, 2); wr(2, 5, 4); wr(2, 6, 7); wr(2, 7, 6); wr(2, 4, 5); wr(2, 1, 1);
    for (int m = 4; m <= 7; m++) begin
      wr(m, 0, 3); wr(m, 4, 2); wr(m, 2, 1); wr(m, 3, (m == 5) ? 1 : 0);
    end
    for (int m = 4; m <= 7; m++) wr(m, 1, 1);
    // ordinary slot 10 permitted; slot 1 requested but no permit
    wr(10, 1, 1); wr(10, 2, 1); wr(10, 3, 1);
    wr(1, 1, 1); wr(1, 2, 1);
    tick(2);
    expect_win(1, 5, "R3 lowest eligible is member 5");
    expect_win(1, 5, "R2 slot 1 without permit skipped");

    wr(1, 3, 1); tick(2);
    expect_win(1, 1, "R10 permit write makes slot 1 win");
    wr(1, 3, 0); tick(2);
    expect_win(1, 5, "R10 permit cleared again");

    done(5);
    check(tx_irq && tx_irq_slot == 4'd5, "R4 irq for slot 5", int'(tx_irq_slot), 5);
    check(ovf_irq == 1'b0, "R8 no alarm while disabled", int'(ovf_irq), 0);
    tick(2);
    expect_win(1, 6, "R5 token moved to 6");

    done(4);
    check(tx_irq && tx_irq_slot == 4'd4, "R9 irq for non-current 4", int'(tx_irq_slot), 4);
    tick(2);
    expect_win(1, 6, "R9 token stays on 6");

    wr(2, 8, 1); wr(2, 7, 7);
    done(6);
    check(ovf_irq && ovf_base == 4'd2, "R7 alarm at index 7", int'(ovf_irq), 1);
    tick(1);
    check(ovf_irq == 1'b0, "R7 alarm is one cycle", int'(ovf_irq), 0);
    tick(1);
    expect_win(1, 7, "R5 token moved to 7");

    done(7);
    check(ovf_irq == 1'b0, "R8 alarm index mismatch", int'(ovf_irq), 0);
    tick(2);
    expect_win(1, 10, "R6 wrapped to 4 which has no request");
    wr(4, 2, 1); tick(2);
    expect_win(1, 4, "R6 token on low bound 4");

    wr(2, 8, 0); wr(2, 7, 5);
    done(4);
    check(ovf_irq == 1'b0, "R8 alarm disabled at matching index", int'(ovf_irq), 0);
    tick(2);
    expect_win(1, 10, "R5 token on 5 without request");
    wr(5, 2, 1); tick(2);
    expect_win(1, 5, "R5 member 5 wins again");

    done(10);
    check(tx_irq && tx_irq_slot == 4'd10, "R4 irq for ordinary slot", int'(tx_irq_slot), 10);
    tick(2);
    expect_win(1, 5, "R9 ordinary completion leaves token");

    done(5); tick(2);
    expect_win(0, 0, "R2 nothing eligible");

    tick(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule